// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

The block guards a processor against lock-up. Software issues control writes that carry a count, a command bit (start or stop) and a 7-bit key. A start write loads an 8-bit down-counter with the count and arms the watchdog. The counter then steps down once per slow tick, which a fixed power-of-two prescaler derives from the system clock. With the default 17-bit prescaler and a 100 MHz clock, the tick rate is about 763 Hz.

Expiry happens in two stages. While the armed counter holds 1, a non-maskable interrupt request is raised. This gives software one tick to record state. When the counter reaches 0, a chip reset pulse of fixed length is driven, and the watchdog then returns to the stopped state.

A write is accepted only when its key is the bitwise inverse of the key in the last accepted write. The stored key starts at zero, so the first accepted key is 0x7F. Writes with any other key are dropped. Restarting a running watchdog is the same operation as kicking it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is stopped, `armed`, `nmi_req` and `chip_rst` are low, and the stored key is 0x00, so the first write that can be accepted carries key 0x7F.
- R2: A write (`wr_en` high for one cycle) is accepted only if `wr_key` equals the last accepted key XOR 0x7F. A write with any other key leaves the counter, the run state and the stored key unchanged.
- R3: An accepted start (`wr_start`=1) with a nonzero count loads that count, raises `armed` on the next cycle and clears the prescaler. The counter then decrements every 2^PRESCALE_W cycles, and the first decrement comes a full period after the write.
- R4: `nmi_req` is high exactly while the watchdog is armed and its counter holds 1.
- R5: When the counter steps from 1 to 0, `armed` falls and `chip_rst` is high for exactly RST_HOLD cycles. After that the watchdog is stopped.
- R6: An accepted start while armed reloads the count and restarts the prescaler, so the expiry moves to a full schedule from that write.
- R7: An accepted stop (`wr_start`=0) halts the countdown and clears `armed` and `nmi_req` on the next cycle. No expiry follows.
- R8: While `chip_rst` is high, every write is ignored and the stored key is not updated.
- R9: An accepted start with count 0 raises `chip_rst` on the next cycle. An accepted start with count 1 raises `nmi_req` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_start | input | 1 | Command: 1 = start/kick, 0 = stop |
| wr_count | input | CNT_W | Start value for the down-counter |
| wr_key | input | KEY_W | Key carried by the write |
| armed | output | 1 | Watchdog is counting down |
| nmi_req | output | 1 | Non-maskable interrupt request (counter at 1) |
| chip_rst | output | 1 | Chip reset pulse (counter reached 0) |

## Verification
Start values are swept over 0, 1, 2, 3, 5 and the 8-bit maximum with a 3-bit prescaler. At every cycle of each run, the three outputs are compared against windows computed from the count, the prescale period and the hold length. A one-cycle shift in either window shows an off-by-one in the prescaler or in the expiry stage.

Four more cases separate accepted writes from dropped ones:
- A kick mid-run.
- A wrong-key write mid-run, which must leave the original schedule intact.
- A stop while the interrupt is raised.
- A correctly keyed write during the reset pulse.

After the dropped writes, a follow-up write with the expected key shows whether the stored key moved.

// File: rtl/keyed_wdog_pkg.sv
`timescale 1ns/1ps
package keyed_wdog_pkg;

    localparam int KEY_W_DEF = 7;
    localparam int CNT_W_DEF = 8;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
    parameter int PRESCALE_W = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam logic [PRESCALE_W-1:0] LAST = '1;

    logic [PRESCALE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = !clear && (div_q == LAST);

    // R3
    tick_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !rst) |=> !tick)
        else $error("tick right after prescaler clear");
endmodule

// File: rtl/wdog_keycheck.sv
`timescale 1ns/1ps
module wdog_keycheck #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             busy,
    output logic             accept
);
    localparam logic [KEY_W-1:0] KEY_MASK = '1;

    logic [KEY_W-1:0] key_q;

    assign accept = wr_en && !busy && (wr_key == (key_q ^ KEY_MASK));

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (accept) begin
            key_q <= wr_key;
        end
    end

    // R2
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !busy) |=> $stable(key_q))
        else $error("stored key moved without a write");

    // R8
    busy_key_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(key_q))
        else $error("stored key moved during reset pulse");
endmodule

// File: rtl/wdog_countdown.sv
`timescale 1ns/1ps
module wdog_countdown
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RST_HOLD = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    output wd_state_e        state,
    output logic             nmi_req,
    output logic             chip_rst
);
    localparam int HOLD_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);
    localparam logic [CNT_W-1:0]  ONE = CNT_W'(1);

    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                WD_IDLE, WD_COUNT: begin
                    if (load) begin
                        cnt_q  <= load_val;
                        hold_q <= '0;
                        state_q <= (load_val == '0) ? WD_BITE : WD_COUNT;
                    end else if (stop) begin
                        state_q <= WD_IDLE;
                    end else if (state_q == WD_COUNT && tick) begin
                        cnt_q <= cnt_q - 1'b1;
                        if (cnt_q == ONE) begin
                            state_q <= WD_BITE;
                            hold_q  <= '0;
                        end
                    end
                end
                WD_BITE: begin
                    if (hold_q == HOLD_LAST) begin
                        state_q <= WD_IDLE;
                    end else begin
                        hold_q <= hold_q + 1'b1;
                    end
                end
                default: state_q <= WD_IDLE;
            endcase
        end
    end

    assign state    = state_q;
    assign nmi_req  = (state_q == WD_COUNT) && (cnt_q == ONE);
    assign chip_rst = (state_q == WD_BITE);

    // R4
    nmi_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nmi_req && chip_rst))
        else $error("nmi and chip reset together");

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_COUNT && !load && !stop) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1))
        else $error("counter moved by more than one");

    // R5
    bite_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_rst && !load) |=> (state_q != WD_COUNT))
        else $error("watchdog re-armed during reset pulse");

    // R7
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !load && state_q != WD_BITE) |=> (state_q == WD_IDLE && !nmi_req))
        else $error("stop did not halt");
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int PRESCALE_W = 17,
    parameter int CNT_W      = CNT_W_DEF,
    parameter int KEY_W      = KEY_W_DEF,
    parameter int RST_HOLD   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_start,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [KEY_W-1:0] wr_key,
    output logic             armed,
    output logic             nmi_req,
    output logic             chip_rst
);
    wd_state_e state;
    logic      accept;
    logic      load;
    logic      stop;
    logic      tick;
    logic      pre_clear;

    wdog_keycheck #(.KEY_W(KEY_W)) u_key (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_key (wr_key),
        .busy   (chip_rst),
        .accept (accept)
    );

    assign load      = accept && wr_start;
    assign stop      = accept && !wr_start;
    assign pre_clear = load || (state != WD_COUNT);

    wdog_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (pre_clear),
        .tick  (tick)
    );

    wdog_countdown #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .stop     (stop),
        .load_val (wr_count),
        .state    (state),
        .nmi_req  (nmi_req),
        .chip_rst (chip_rst)
    );

    assign armed = (state == WD_COUNT);

    // R4
    nmi_armed_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> armed)
        else $error("nmi while not armed");

    // R9
    zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load && wr_count == '0) |=> chip_rst)
        else $error("zero start did not bite");
endmodule

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
    localparam int PW = 3;
    localparam int P  = 1 << PW;
    localparam int H  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_start = 1'b0;
    logic [7:0] wr_count = '0;
    logic [6:0] wr_key = '0;
    logic       armed, nmi_req, chip_rst;

    int total = 0;
    int bad   = 0;
    logic [6:0] bkey = 7'h00;

    always #4 clk = ~clk;

    keyed_wdog #(.PRESCALE_W(PW), .CNT_W(8), .KEY_W(7), .RST_HOLD(H)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_start(wr_start),
        .wr_count(wr_count), .wr_key(wr_key),
        .armed(armed), .nmi_req(nmi_req), .chip_rst(chip_rst)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wr(input logic st, input int cnt, input logic [6:0] key);
        @(negedge clk);
        wr_en = 1'b1; wr_start = st; wr_count = 8'(cnt); wr_key = key;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic good_wr(input logic st, input int cnt);
        bkey = bkey ^ 7'h7F;
        wr(st, cnt, bkey);
    endtask

    // checks outputs for m = from..to cycles after the accepting edge
    task automatic watch(input string req, input int n, input int from, input int to);
        for (int m = from; m <= to; m++) begin
            logic e_rst, e_nmi, e_arm;
            e_rst = (m >= n * P) && (m < n * P + H);
            e_nmi = (n >= 1) && (m >= (n - 1) * P) && (m < n * P);
            e_arm = (n >= 1) && (m < n * P);
            check(req, "chip_rst", chip_rst, e_rst);
            check(req, "nmi_req", nmi_req, e_nmi);
            check(req, "armed", armed, e_arm);
            @(negedge clk);
        end
    endtask

    task automatic quiet(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            check(req, "chip_rst", chip_rst, 1'b0);
            check(req, "nmi_req", nmi_req, 1'b0);
            check(req, "armed", armed, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        quiet("R1", 3);

        // R2: wrong keys while stopped are dropped (0x00 is wrong first key)
        wr(1'b1, 3, 7'h00);
        quiet("R2", 2 * P);
        wr(1'b1, 3, 7'h2A);
        quiet("R2", 2 * P);

        // R1 R3 R4 R5 R9: sweep of start values, first key 0x7F
        begin
            int vals[6] = '{1, 2, 0, 3, 5, 255};
            foreach (vals[i]) begin
                good_wr(1'b1, vals[i]);
                watch(vals[i] == 0 ? "R9" : (vals[i] == 1 ? "R9" : "R3"),
                      vals[i], 0, vals[i] * P + H + 2);
            end
        end

        // R6: kick mid-run moves expiry
        good_wr(1'b1, 3);
        watch("R6", 3, 0, P + 2);
        good_wr(1'b1, 3);
        watch("R6", 3, 0, 3 * P + H + 2);

        // R2: wrong key mid-run leaves schedule intact
        good_wr(1'b1, 4);
        watch("R2", 4, 0, 9);
        wr(1'b0, 0, bkey);          // repeats last key: wrong
        watch("R2", 4, 12, 4 * P + H + 2);
        good_wr(1'b1, 2);           // stored key was untouched
        watch("R2", 2, 0, 2 * P + H + 2);

        // R7: stop during nmi
        good_wr(1'b1, 5);
        watch("R7", 5, 0, 4 * P + 1);
        good_wr(1'b0, 0);
        quiet("R7", 6 * P);

        // R8: keyed write during reset pulse is ignored, key not consumed
        good_wr(1'b1, 1);
        watch("R8", 1, 0, P);
        wr(1'b1, 7, bkey ^ 7'h7F);
        watch("R8", 1, P + 3, P + H + 2 * P);
        good_wr(1'b1, 2);
        watch("R8", 2, 0, 2 * P + H + 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule